// File: doc/BRIEF.md
# Two-Wire Clock Output Enable Register

This block is a two-wire serial slave that holds the run/stop controls for a group of clock outputs. A host writes a fixed block of seven control bytes. Each implemented bit of that block lets one clock output run or holds it low. The host can also read the block back. The serial lines are sampled by the system clock. The slave pulls SDA low through an open-drain output enable and never drives SCL.

Every gated output has its own free-running source clock. The stored enable bit crosses into that source domain through a synchronizer. It is then applied only while the source clock is low, so the output never shows a shortened pulse. Output k is controlled by bit k mod 8 of control byte k/8. Positions that a mask parameter marks as reserved do not gate anything and read back as 0.

Top module: `clk_en_regs`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read). Any other address byte is not acknowledged: SDA stays released at the acknowledge bit, and later bytes up to the next START are neither acknowledged nor stored.
- R2: A write consists of the address, two leading bytes and then data bytes 0 to 6. The slave acknowledges every one of these bytes by pulling SDA low in the ninth clock. A data byte beyond byte 6 is not acknowledged and changes nothing.
- R3: The two bytes between the write address and data byte 0 are acknowledged, and their values have no effect on any register or output.
- R4: A read returns, MSB first, the value 7 and then control bytes 0 to 6 in order.
- R5: After reset, every implemented enable bit is 1 and every output runs. A read then returns 0xFB for byte 0, 0x7B for byte 1 and 0x00 for bytes 2 to 6.
- R6: Output k follows bit k mod 8 of byte k/8. A 1 lets the output run, and a 0 holds it low.
- R7: The reserved positions are bits 2, 10 and 15 (mask 0x7BFB) and every bit of bytes 2 to 6. Writing them has no effect on any output, and they read back as 0.
- R8: A data byte is stored only after its ninth (acknowledge) clock. If a write ends early, the bytes already completed keep their new values and all other bytes keep their old values.
- R9: An output changes between running and stopped only while its source clock is low. No high phase of an output is shorter than a high phase of its source clock.
- R10: A START in the middle of a transaction makes the next byte an address byte. A STOP returns the slave to idle and releases SDA.
- R11: If the host does not acknowledge a read byte, the slave stops driving SDA until the next START.
- R12: The slave changes its SDA drive only after a falling SCL edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls the serial data line low |
| clkIn | input | NUM_GATED (16) | Free-running source clocks |
| clkOut | output | NUM_GATED (16) | Gated clock outputs |

## Verification
The bench builds the block with its default parameters. These are sixteen gated outputs covering bytes 0 and 1, a mask with three reserved positions in those bytes, and a seven-byte block, so bytes 2 to 6 are reserved in full. With this setup the bench can reach, in one configuration, a mixed byte containing both reserved and live bits and bytes that are reserved in full. The bench also covers the slave's refusal of an eighth data byte, the end of a read at the last byte, and reads and writes aborted at several points in the byte sequence.

// File: rtl/clk_en_pkg.sv
`timescale 1ns/1ps
package clk_en_pkg;
  // Width of the byte index carried in the strobe struct (supports up to 14 bytes).
  localparam int IDX_W = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WCMD, S_WCNT, S_WDATA, S_RDATA, S_HALT
  } busState_t;

  // Strobes from the bus controller to the register datapath.
  typedef struct packed {
    logic             shiftIn;   // capture rxBit into the receive shifter
    logic             rxBit;     // synchronized SDA level
    logic             commit;    // store received byte at idx
    logic             loadTx;    // load read byte idx into transmit shifter
    logic             shiftTx;   // advance transmit shifter by one bit
    logic [IDX_W-1:0] idx;       // byte index for commit/loadTx
    logic             busEdge;   // falling SCL, START or STOP seen this cycle
    logic             stopSeen;  // STOP seen this cycle
  } strobe_t;
endpackage

// File: rtl/serial_ctl.sv
`timescale 1ns/1ps
module serial_ctl
  import clk_en_pkg::*;
#(
  parameter logic [7:0] WR_ADDR   = 8'hD2,
  parameter logic [7:0] RD_ADDR   = 8'hD3,
  parameter int         NUM_BYTES = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output strobe_t    strb,
  output logic       sdaOe
);
  localparam logic [IDX_W-1:0] IDX_MAX  = {IDX_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_BYTES);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       startEv, stopEv, riseEv, fallEv;
  busState_t  state;
  logic [3:0] bitCnt;
  logic [IDX_W-1:0] idx, idxNext;
  logic       ackDrive, txDrive, hostNack;
  logic       active, ackOk;

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign riseEv  = sclS & ~sclPrev;
  assign fallEv  = ~sclS & sclPrev;
  assign active  = (state != S_IDLE) && (state != S_HALT);
  assign idxNext = (idx == IDX_MAX) ? idx : idx + 1'b1;
  assign sdaOe   = ackDrive | (txDrive & ~txMsb);

  always_comb begin
    unique case (state)
      S_ADDR:         ackOk = (rxByte == WR_ADDR) || (rxByte == RD_ADDR);
      S_WCMD, S_WCNT: ackOk = 1'b1;
      S_WDATA:        ackOk = (idx < IDX_LAST);
      default:        ackOk = 1'b0;
    endcase
  end

  always_comb begin
    strb          = '0;
    strb.rxBit    = sdaS;
    strb.busEdge  = fallEv | startEv | stopEv;
    strb.stopSeen = stopEv;
    if (!startEv && !stopEv && active) begin
      if (riseEv && bitCnt < 4'd8 && state != S_RDATA) strb.shiftIn = 1'b1;
      if (fallEv) begin
        if (bitCnt == 4'd9) begin
          if (state == S_WDATA) begin
            strb.commit = 1'b1;
            strb.idx    = idx;
          end else if (state == S_ADDR && rxByte == RD_ADDR) begin
            strb.loadTx = 1'b1;
            strb.idx    = '0;
          end else if (state == S_RDATA && !hostNack) begin
            strb.loadTx = 1'b1;
            strb.idx    = idxNext;
          end
        end else if (bitCnt >= 4'd1 && bitCnt <= 4'd7 && state == S_RDATA) begin
          strb.shiftTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync  <= 2'b11;
      sdaSync  <= 2'b11;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      state    <= S_IDLE;
      bitCnt   <= '0;
      idx      <= '0;
      ackDrive <= 1'b0;
      txDrive  <= 1'b0;
      hostNack <= 1'b0;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      if (startEv) begin
        state    <= S_ADDR;
        bitCnt   <= '0;
        idx      <= '0;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
        hostNack <= 1'b0;
      end else if (stopEv) begin
        state    <= S_IDLE;
        ackDrive <= 1'b0;
        txDrive  <= 1'b0;
      end else if (active) begin
        if (riseEv) begin
          if (bitCnt < 4'd9) bitCnt <= bitCnt + 1'b1;
          if (bitCnt == 4'd8 && state == S_RDATA) hostNack <= sdaS;
        end else if (fallEv) begin
          if (bitCnt == 4'd8) begin
            if (state == S_RDATA) txDrive <= 1'b0;
            else if (ackOk)       ackDrive <= 1'b1;
            else                  state <= S_HALT;
          end else if (bitCnt == 4'd9) begin
            bitCnt   <= '0;
            ackDrive <= 1'b0;
            unique case (state)
              S_ADDR: begin
                if (rxByte == RD_ADDR) begin
                  state   <= S_RDATA;
                  idx     <= '0;
                  txDrive <= 1'b1;
                end else begin
                  state <= S_WCMD;
                end
              end
              S_WCMD: state <= S_WCNT;
              S_WCNT: begin
                state <= S_WDATA;
                idx   <= '0;
              end
              S_WDATA: idx <= idxNext;
              S_RDATA: begin
                if (hostNack) begin
                  state   <= S_HALT;
                  txDrive <= 1'b0;
                end else begin
                  idx     <= idxNext;
                  txDrive <= 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfg_bank.sv
`timescale 1ns/1ps
module cfg_bank
  import clk_en_pkg::*;
#(
  parameter int                   NUM_BYTES = 7,
  parameter int                   NUM_GATED = 16,
  parameter logic [NUM_GATED-1:0] IMPL_MASK = 16'h7BFB
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  output logic [7:0]           rxByte,
  output logic                 txMsb,
  output logic [NUM_GATED-1:0] enVec
);
  localparam int IMG_BITS = NUM_BYTES * 8;

  logic [7:0]           rxShift, txShift, rdByte;
  logic [NUM_GATED-1:0] enReg;
  logic [IMG_BITS-1:0]  image;

  for (genvar k = 0; k < NUM_GATED; k++) begin : g_bit
    if (IMPL_MASK[k]) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 1'b1;
        else if (strb.commit && strb.idx == IDX_W'(k / 8)) q <= rxShift[k % 8];
      end
      assign enReg[k] = q;
    end else begin : g_rsvd
      assign enReg[k] = 1'b1;
    end
  end

  for (genvar k = 0; k < IMG_BITS; k++) begin : g_img
    if (k < NUM_GATED) begin : g_map
      assign image[k] = enReg[k] & IMPL_MASK[k];
    end else begin : g_zero
      assign image[k] = 1'b0;
    end
  end

  always_comb begin
    rdByte = 8'hFF;
    if (strb.idx == '0) rdByte = 8'(NUM_BYTES);
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (strb.idx == IDX_W'(b + 1)) rdByte = image[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= 8'hFF;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[6:0], strb.rxBit};
      if (strb.loadTx)       txShift <= rdByte;
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txShift[7];
  assign enVec  = enReg;
endmodule

// File: rtl/clk_gate_bank.sv
`timescale 1ns/1ps
module clk_gate_bank #(
  parameter int NUM_GATED   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 rstN,
  input  logic [NUM_GATED-1:0] enVec,
  input  logic [NUM_GATED-1:0] clkIn,
  output logic [NUM_GATED-1:0] clkOut
);
  for (genvar i = 0; i < NUM_GATED; i++) begin : g_gate
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   enLow;

    always_ff @(posedge clkIn[i] or negedge rstN) begin
      if (!rstN) syncQ <= '1;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], enVec[i]};
    end

    // Enable only moves on the falling edge, while the source is low.
    always_ff @(negedge clkIn[i] or negedge rstN) begin
      if (!rstN) enLow <= 1'b1;
      else       enLow <= syncQ[SYNC_STAGES-1];
    end

    assign clkOut[i] = clkIn[i] & enLow;
  end
endmodule

// File: rtl/clk_en_regs.sv
`timescale 1ns/1ps
module clk_en_regs
  import clk_en_pkg::*;
#(
  parameter logic [7:0]           WR_ADDR     = 8'hD2,
  parameter logic [7:0]           RD_ADDR     = 8'hD3,
  parameter int                   NUM_BYTES   = 7,
  parameter int                   NUM_GATED   = 16,
  parameter logic [NUM_GATED-1:0] IMPL_MASK   = 16'h7BFB,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaOe,
  input  logic [NUM_GATED-1:0] clkIn,
  output logic [NUM_GATED-1:0] clkOut
);
  strobe_t              strb;
  logic [7:0]           rxByte;
  logic                 txMsb;
  logic [NUM_GATED-1:0] enVec;

  serial_ctl #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR), .NUM_BYTES(NUM_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txMsb(txMsb), .strb(strb), .sdaOe(sdaOe)
  );

  cfg_bank #(.NUM_BYTES(NUM_BYTES), .NUM_GATED(NUM_GATED), .IMPL_MASK(IMPL_MASK)) u_bank (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rxByte(rxByte), .txMsb(txMsb), .enVec(enVec)
  );

  clk_gate_bank #(.NUM_GATED(NUM_GATED), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .rstN(rstN), .enVec(enVec), .clkIn(clkIn), .clkOut(clkOut)
  );
endmodule

// File: rtl/clk_en_regs_chk.sv
`timescale 1ns/1ps
module clk_en_regs_chk
  import clk_en_pkg::*;
#(
  parameter int NUM_GATED = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sdaOe,
  input strobe_t              strb,
  input logic [NUM_GATED-1:0] enVec
);
  // R8: enables move only when a completed byte is committed
  a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(enVec));

  // R12: SDA drive changes only after falling SCL, START or STOP
  a_r12_sda_moves_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(strb.busEdge));

  // R10: a STOP releases the data line
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopSeen |=> !sdaOe);

  // R2: at most one datapath action per cycle
  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.commit, strb.loadTx, strb.shiftTx, strb.shiftIn}));
endmodule

bind clk_en_regs clk_en_regs_chk #(.NUM_GATED(NUM_GATED)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .strb(strb), .enVec(enVec)
);

// File: tb/sim_clk_en_regs.sv
`timescale 1ns/1ps
module sim_clk_en_regs;
  localparam int          CLK_PERIOD = 10;
  localparam int          GCLK_HALF  = 13;
  localparam int          Q          = 50;
  localparam logic [15:0] MASK       = 16'h7BFB;
  localparam logic [7:0]  WR_A       = 8'hD2;
  localparam logic [7:0]  RD_A       = 8'hD3;
  // {cmd, count, byte0, byte1}
  localparam logic [31:0] VEC [4] = '{32'h00_00_00_00, 32'hFF_07_FF_FF,
                                      32'h5A_3C_A5_5A, 32'h11_22_3C_C3};

  logic clk = 1'b0, gclk = 1'b0, rstN = 1'b0;
  logic hostScl = 1'b1, hostSda = 1'b1;
  logic sdaOe, sdaLine;
  logic [15:0] clkOut;
  int checkCnt = 0, failCnt = 0, runtCnt = 0;
  bit done = 1'b0;

  logic [7:0] wrData [7];
  logic [7:0] rdData [7];
  logic [7:0] rdCnt;
  logic       rdAddrAck;
  int         wrNacks;
  logic [7:0] expB0, expB1;
  logic [15:0] curOut;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(GCLK_HALF) gclk = ~gclk;
  assign sdaLine = hostSda & ~sdaOe;

  clk_en_regs u0 (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .clkIn({16{gclk}}), .clkOut(clkOut)
  );

  // R9 monitor: output high phase stays whole, output never high while source low
  always @(posedge gclk) begin
    logic [15:0] early;
    #2 early = clkOut;
    #8 if (rstN && clkOut !== early) runtCnt++;
  end
  always @(negedge gclk) begin
    #2 if (rstN && clkOut !== 16'h0) runtCnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bitOut(input logic b);
    hostSda = b; #Q; hostScl = 1'b1; #Q; hostScl = 1'b0; #Q;
  endtask
  task automatic bitIn(output logic b);
    hostSda = 1'b1; #Q; hostScl = 1'b1; #(Q/2); b = sdaLine; #(Q/2); hostScl = 1'b0; #Q;
  endtask
  task automatic i2cStart();
    hostSda = 1'b1; #Q; hostScl = 1'b1; #Q; hostSda = 1'b0; #Q; hostScl = 1'b0; #Q;
  endtask
  task automatic i2cStop();
    hostSda = 1'b0; #Q; hostScl = 1'b1; #Q; hostSda = 1'b1; #Q;
  endtask
  task automatic sendByte(input logic [7:0] b, output logic ackBit);
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    bitIn(ackBit);
  endtask
  task automatic recvByte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bitIn(b[i]);
    bitOut(nack);
  endtask

  task automatic doWrite(input logic [7:0] cmd, input logic [7:0] cnt, input int n);
    logic a;
    wrNacks = 0;
    i2cStart();
    sendByte(WR_A, a); wrNacks += int'(a);
    sendByte(cmd, a);  wrNacks += int'(a);
    sendByte(cnt, a);  wrNacks += int'(a);
    for (int i = 0; i < n; i++) begin sendByte(wrData[i], a); wrNacks += int'(a); end
    i2cStop();
  endtask

  task automatic doRead();
    i2cStart();
    sendByte(RD_A, rdAddrAck);
    recvByte(1'b0, rdCnt);
    for (int i = 0; i < 7; i++) recvByte(i == 6, rdData[i]);
    i2cStop();
  endtask

  task automatic sampleOut();
    repeat (6) @(posedge gclk);
    #6 curOut = clkOut;
  endtask

  function automatic logic [15:0] expOut(input logic [7:0] b0, input logic [7:0] b1);
    return {b1, b0} | ~MASK;
  endfunction

  task automatic checkImage(input string req);
    logic [7:0] orRest;
    doRead();
    orRest = 8'h0;
    for (int i = 2; i < 7; i++) orRest |= rdData[i];
    check(rdData[0] == expB0, req, rdData[0], expB0);
    check(rdData[1] == expB1, req, rdData[1], expB1);
    check(orRest == 8'h0, {req, " reserved bytes"}, orRest, 0);
    sampleOut();
    check(curOut == expOut(expB0, expB1), {req, " outputs"}, curOut, expOut(expB0, expB1));
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    logic [7:0] anyDrive;
    #(CLK_PERIOD*5 + 3);
    rstN = 1'b1;
    #(CLK_PERIOD*5);

    // R5: reset state
    sampleOut();
    check(curOut == 16'hFFFF, "R5 outputs after reset", curOut, 16'hFFFF);
    expB0 = 8'hFB; expB1 = 8'h7B;
    checkImage("R5 readback");
    check(rdCnt == 8'd7, "R4 count byte", rdCnt, 7);
    check(rdAddrAck == 1'b0, "R1 read address ack", rdAddrAck, 0);

    // Vector table: R2 R3 R4 R6 R7
    for (int v = 0; v < 4; v++) begin
      wrData[0] = VEC[v][15:8];
      wrData[1] = VEC[v][7:0];
      for (int i = 2; i < 7; i++) wrData[i] = VEC[v][31:24] ^ 8'(i * 37);
      doWrite(VEC[v][31:24], VEC[v][23:16], 7);
      check(wrNacks == 0, "R2 all write bytes acked", wrNacks, 0);
      expB0 = VEC[v][15:8] & MASK[7:0];
      expB1 = VEC[v][7:0] & MASK[15:8];
      checkImage("R6 R7 R3 vector");
      check(rdCnt == 8'd7, "R4 count byte", rdCnt, 7);
    end

    // R1: foreign address not acked, following byte ignored
    i2cStart();
    sendByte(8'hA4, a);
    check(a == 1'b1, "R1 foreign address nack", a, 1);
    sendByte(8'h00, a);
    check(a == 1'b1, "R1 byte after foreign address", a, 1);
    i2cStop();
    checkImage("R1 unchanged");

    // R8: byte 0 completed, byte 1 cut after four bits
    i2cStart();
    sendByte(WR_A, a); sendByte(8'h00, a); sendByte(8'h00, a);
    sendByte(8'h00, a);
    for (int i = 0; i < 4; i++) bitOut(1'b0);
    hostScl = 1'b0;
    i2cStop();
    expB0 = 8'h00;
    checkImage("R8 partial write");

    // R2: eighth data byte refused
    for (int i = 0; i < 7; i++) wrData[i] = 8'hFF;
    i2cStart();
    sendByte(WR_A, a); sendByte(8'h00, a); sendByte(8'h00, a);
    for (int i = 0; i < 7; i++) sendByte(wrData[i], a);
    sendByte(8'h00, a);
    check(a == 1'b1, "R2 extra byte nack", a, 1);
    i2cStop();
    expB0 = 8'hFB; expB1 = 8'h7B;
    checkImage("R2 extra byte ignored");

    // R10: repeated start mid-write turns next byte into an address
    i2cStart();
    sendByte(WR_A, a); sendByte(8'h55, a); sendByte(8'h01, a);
    sendByte(8'h12, a);
    sendByte(8'hFF, a);
    for (int i = 0; i < 3; i++) bitOut(1'b0);
    i2cStart();
    sendByte(RD_A, a);
    check(a == 1'b0, "R10 address after repeated start", a, 0);
    recvByte(1'b0, b);
    check(b == 8'd7, "R10 count after repeated start", b, 7);
    recvByte(1'b1, b);
    check(b == 8'h12, "R10 byte0 after repeated start", b, 8'h12);
    i2cStop();
    expB0 = 8'h12; expB1 = 8'h7B;
    checkImage("R10 image");

    // R11: host nack ends the read; slave stays off the line
    i2cStart();
    sendByte(RD_A, a);
    recvByte(1'b1, b);
    anyDrive = 8'h0;
    for (int i = 0; i < 2; i++) begin
      logic [7:0] r;
      recvByte(1'b1, r);
      anyDrive |= ~r;
    end
    check(anyDrive == 8'h0, "R11 released after host nack", anyDrive, 0);
    i2cStop();
    check(sdaOe == 1'b0, "R10 released after stop", sdaOe, 0);
    doRead();
    check(rdData[0] == 8'h12, "R11 read after new start", rdData[0], 8'h12);

    // R9: no runt pulses across every enable change above
    check(runtCnt == 0, "R9 glitch-free gating", runtCnt, 0);

    done = 1'b1;
    finishRun();
  end
endmodule